// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Column Sequencer

This block keeps the programmable operating settings of a synchronous DRAM and, for every read or write command, produces the order in which column addresses are visited during the burst. A mode-set strobe loads the burst length, the ordering, the CAS latency and the write-burst policy from an opcode word. A start strobe gives the first column and says whether the access is a write. A stop strobe ends a burst early. A clock enable input suspends the whole block.

Each cycle the sequencer outputs the column of the current beat, a flag showing that a burst is running, and a flag marking the final beat. Linear bursts count upward and wrap inside the aligned block of the burst length. Interleaved bursts XOR the beat number into the low column bits. A full-page burst walks all columns of the row and wraps until it is stopped. Moving data and storing it are handled elsewhere.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset no burst is active, the final-beat flag is low, the CAS latency output reads 3, the burst length is 1, the ordering is linear and writes use the burst length.
- R2: A mode-set with clock enable high loads the burst length from opcode bits 2:0, with 000=1, 001=2, 010=4, 011=8 and 111=full page. A following burst runs for exactly that many beats.
- R3: When bit 3 is 0 (linear), beat k of a length-N burst has column (start + k) mod N in the low log2(N) bits. The upper bits equal those of the start column.
- R4: When bit 3 is 1 (interleaved), beat k of a length-N burst has column start XOR k in the low log2(N) bits. The upper bits are unchanged.
- R5: Opcode bits 6:4 set the CAS latency: 010 gives 2 and 011 gives 3. The cas_latency output shows the value in the cycle after the mode-set.
- R6: A reserved length code (100, 101, 110) or a reserved latency code (any other than 010 and 011) leaves that field at its previous value. An opcode with bit 7, bit 8 or any bit above 9 set is ignored completely.
- R7: A full-page burst steps linearly through all 256 columns and wraps from 255 to 0. It never raises the final-beat flag and runs until stopped or restarted, even when bit 3 requests interleaving.
- R8: A stop strobe with clock enable high clears burst_active in the next cycle.
- R9: When opcode bit 9 is 1, every write is a single beat and reads keep the programmed length. When bit 9 is 0, writes use the programmed length.
- R10: While cke is low, the column, the burst flags and the mode settings hold. Start, stop and mode-set strobes in those cycles are ignored.
- R11: A start strobe during a running burst abandons that burst. The next cycle shows the new start column as beat 0 of a fresh burst.
- R12: last_beat is high exactly on the final beat of a non-full-page burst, and burst_active falls in the following cycle unless a new start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| mrs_valid | input | 1 | Mode-set strobe |
| mrs_opcode | input | ADDR_W | Mode-set opcode word |
| cmd_start | input | 1 | Read or write command, starts a burst |
| cmd_write | input | 1 | High when the started access is a write |
| cmd_col | input | COL_W | Start column of the burst |
| cmd_stop | input | 1 | Burst stop strobe |
| col_addr | output | COL_W | Column of the current beat |
| burst_active | output | 1 | A burst is running |
| last_beat | output | 1 | The current beat is the final one |
| cas_latency | output | 2 | Programmed CAS latency (2 or 3) |

## Verification
The bench uses the default ADDR_W of 11 and COL_W of 8. This makes the full 256-column page reachable, so a full-page run of 300 beats crosses the wrap from 255 to 0. With these widths every length code, including bursts of eight, fits inside a column with upper bits left to check for disturbance. The 11-bit opcode also contains reserved bits both between and above the used fields, so the rule that ignores a whole mode-set can be exercised.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    // Opcode field positions; the mode-set word is decoded at these bits.
    localparam int OP_BL_LSB = 0;
    localparam int OP_BT_BIT = 3;
    localparam int OP_CL_LSB = 4;
    localparam int OP_WB_BIT = 9;

    typedef enum logic [2:0] {
        BL_1    = 3'd0,
        BL_2    = 3'd1,
        BL_4    = 3'd2,
        BL_8    = 3'd3,
        BL_FULL = 3'd4
    } burst_len_e;

    typedef struct packed {
        burst_len_e bl;
        logic       ilv;
        logic       cl3;
        logic       wr_single;
    } mode_t;

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_burst_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] opcode,
    output mode_t             mode
);

    // Bits that a normal mode-set must leave at zero.
    localparam logic [ADDR_W-1:0] USED_MASK =
        ADDR_W'((1 << OP_WB_BIT) | 'h7F);
    localparam logic [ADDR_W-1:0] RSV_MASK = ~USED_MASK;

    mode_t mode_d, mode_q;
    logic  rsv_hit;

    always_comb begin
        mode_d  = mode_q;
        rsv_hit = |(opcode & RSV_MASK);
        if (load && !rsv_hit) begin
            case (opcode[OP_BL_LSB +: 3])
                3'b000:  mode_d.bl = BL_1;
                3'b001:  mode_d.bl = BL_2;
                3'b010:  mode_d.bl = BL_4;
                3'b011:  mode_d.bl = BL_8;
                3'b111:  mode_d.bl = BL_FULL;
                default: mode_d.bl = mode_q.bl;
            endcase
            mode_d.ilv = opcode[OP_BT_BIT];
            case (opcode[OP_CL_LSB +: 3])
                3'b010:  mode_d.cl3 = 1'b0;
                3'b011:  mode_d.cl3 = 1'b1;
                default: mode_d.cl3 = mode_q.cl3;
            endcase
            mode_d.wr_single = opcode[OP_WB_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{bl: BL_1, ilv: 1'b0, cl3: 1'b1, wr_single: 1'b0};
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/sdr_col_gen.sv
module sdr_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] lin_col;
    logic [COL_W-1:0] xor_col;
    logic [COL_W-1:0] low_col;

    always_comb begin
        lin_col = base + beat;
        xor_col = base ^ beat;
        low_col = ilv ? xor_col : lin_col;
        col     = (base & ~mask) | (low_col & mask);
    end

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_burst_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              mrs_valid,
    input  logic [ADDR_W-1:0] mrs_opcode,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              burst_active,
    output logic              last_beat,
    output logic [1:0]        cas_latency
);

    typedef struct packed {
        logic             active;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic             full;
        logic             ilv;
    } seq_t;

    function automatic logic [COL_W-1:0] len_mask(burst_len_e bl);
        case (bl)
            BL_2:    return COL_W'(1);
            BL_4:    return COL_W'(3);
            BL_8:    return COL_W'(7);
            BL_FULL: return '1;
            default: return '0;
        endcase
    endfunction

    mode_t mode;
    seq_t  seq_d, seq_q;
    logic  is_last;
    logic  single_wr;

    sdr_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cke && mrs_valid),
        .opcode (mrs_opcode),
        .mode   (mode)
    );

    always_comb begin
        seq_d     = seq_q;
        is_last   = seq_q.active && !seq_q.full && (seq_q.beat == seq_q.mask);
        single_wr = cmd_write && mode.wr_single;
        if (cke) begin
            if (cmd_start) begin
                seq_d.active = 1'b1;
                seq_d.base   = cmd_col;
                seq_d.beat   = '0;
                seq_d.full   = (mode.bl == BL_FULL) && !single_wr;
                seq_d.mask   = single_wr ? '0 : len_mask(mode.bl);
                seq_d.ilv    = mode.ilv && (mode.bl != BL_FULL);
            end else if (cmd_stop) begin
                seq_d.active = 1'b0;
            end else if (seq_q.active) begin
                if (is_last) begin
                    seq_d.active = 1'b0;
                end else begin
                    seq_d.beat = seq_q.beat + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    sdr_col_gen #(.COL_W(COL_W)) u_col (
        .base (seq_q.base),
        .beat (seq_q.beat),
        .mask (seq_q.mask),
        .ilv  (seq_q.ilv),
        .col  (col_addr)
    );

    assign burst_active = seq_q.active;
    assign last_beat    = is_last;
    assign cas_latency  = mode.cl3 ? 2'd3 : 2'd2;

endmodule

// File: rtl/sdr_burst_seq_chk.sv
module sdr_burst_seq_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             cmd_start,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_stop,
    input logic [COL_W-1:0] col_addr,
    input logic             burst_active,
    input logic             last_beat,
    input logic [1:0]       cas_latency
);

    p_cke_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(col_addr) && $stable(burst_active) && $stable(cas_latency));

    p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cke && cmd_stop && !cmd_start |=> !burst_active);

    p_restart_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cke && cmd_start |=> burst_active && (col_addr == $past(cmd_col)));

    p_last_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cke && last_beat && !cmd_start |=> !burst_active);

    p_last_in_burst_r12: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> burst_active);

    p_cas_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_latency == 2'd2) || (cas_latency == 2'd3));

endmodule

bind sdr_burst_seq sdr_burst_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke          (cke),
    .cmd_start    (cmd_start),
    .cmd_col      (cmd_col),
    .cmd_stop     (cmd_stop),
    .col_addr     (col_addr),
    .burst_active (burst_active),
    .last_beat    (last_beat),
    .cas_latency  (cas_latency)
);

// File: tb/sdr_burst_seq_bench.sv
module sdr_burst_seq_bench;

    localparam int ADDR_W = 11;
    localparam int COL_W  = 8;
    localparam int NVEC   = 10;

    // {opcode[11], col[8], write[1], beats[9], interleaved[1], cas[2]}
    localparam logic [31:0] VEC [NVEC] = '{
        {11'h022, 8'h15, 1'b0, 9'd4, 1'b0, 2'd2},
        {11'h02A, 8'h15, 1'b0, 9'd4, 1'b1, 2'd2},
        {11'h033, 8'h3D, 1'b0, 9'd8, 1'b0, 2'd3},
        {11'h03B, 8'h3D, 1'b0, 9'd8, 1'b1, 2'd3},
        {11'h031, 8'hFF, 1'b0, 9'd2, 1'b0, 2'd3},
        {11'h039, 8'h80, 1'b0, 9'd2, 1'b1, 2'd3},
        {11'h030, 8'h42, 1'b1, 9'd1, 1'b0, 2'd3},
        {11'h232, 8'h10, 1'b1, 9'd1, 1'b0, 2'd3},
        {11'h232, 8'h11, 1'b0, 9'd4, 1'b0, 2'd3},
        {11'h022, 8'h07, 1'b1, 9'd4, 1'b0, 2'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cke = 1'b1;
    logic              mrs_valid = 1'b0;
    logic [ADDR_W-1:0] mrs_opcode = '0;
    logic              cmd_start = 1'b0;
    logic              cmd_write = 1'b0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic              cmd_stop = 1'b0;
    logic [COL_W-1:0]  col_addr;
    logic              burst_active;
    logic              last_beat;
    logic [1:0]        cas_latency;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sdr_burst_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_sdr_burst_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke          (cke),
        .mrs_valid    (mrs_valid),
        .mrs_opcode   (mrs_opcode),
        .cmd_start    (cmd_start),
        .cmd_write    (cmd_write),
        .cmd_col      (cmd_col),
        .cmd_stop     (cmd_stop),
        .col_addr     (col_addr),
        .burst_active (burst_active),
        .last_beat    (last_beat),
        .cas_latency  (cas_latency)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int col, input int k, input int n, input bit ilv);
        int mask = n - 1;
        int low  = ilv ? ((col ^ k) & mask) : ((col + k) & mask);
        return (col & ~mask & 'hFF) | low;
    endfunction

    task automatic mode_set(input logic [ADDR_W-1:0] op);
        @(negedge clk);
        mrs_valid  = 1'b1;
        mrs_opcode = op;
        @(negedge clk);
        mrs_valid  = 1'b0;
    endtask

    task automatic run_burst(input int col, input bit wr, input int n, input bit ilv,
                             input string req);
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_col   = COL_W'(col);
        cmd_write = wr;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            chk(int'(col_addr) == exp_col(col, k, n, ilv), req,
                int'(col_addr), exp_col(col, k, n, ilv));
            chk(burst_active == 1'b1, {req, " active"}, int'(burst_active), 1);
            chk(last_beat == (k == n - 1), "R12 last flag", int'(last_beat),
                int'(k == n - 1));
        end
        @(negedge clk);
        chk(burst_active == 1'b0, "R12 ends after last", int'(burst_active), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(burst_active == 1'b0, "R1 active", int'(burst_active), 0);
        chk(last_beat == 1'b0, "R1 last", int'(last_beat), 0);
        chk(cas_latency == 2'd3, "R1 cas", int'(cas_latency), 3);
        run_burst(8'h23, 1'b1, 1, 1'b0, "R1 default length");

        // Table of modes: R2 lengths, R3 linear, R4 interleaved, R5 cas, R9 writes
        for (int i = 0; i < NVEC; i++) begin
            mode_set(VEC[i][31:21]);
            chk(int'(cas_latency) == int'(VEC[i][1:0]), "R5 cas",
                int'(cas_latency), int'(VEC[i][1:0]));
            run_burst(int'(VEC[i][20:13]), VEC[i][12], int'(VEC[i][11:3]), VEC[i][2],
                      "R2 R3 R4 R9 table");
        end

        // R6 reserved codes keep previous length 4 and latency 2
        mode_set(11'h005);
        chk(cas_latency == 2'd2, "R6 cas kept", int'(cas_latency), 2);
        run_burst(8'h15, 1'b0, 4, 1'b0, "R6 length kept");
        mode_set(11'h1B3);
        chk(cas_latency == 2'd2, "R6 opcode ignored", int'(cas_latency), 2);
        run_burst(8'h15, 1'b0, 4, 1'b0, "R6 opcode ignored");
        mode_set(11'h433);
        chk(cas_latency == 2'd2, "R6 high bit ignored", int'(cas_latency), 2);

        // R7 full page wrap and stop
        mode_set(11'h027);
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_col   = 8'hFE;
        cmd_write = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            chk(int'(col_addr) == ((254 + k) & 255), "R7 full page col",
                int'(col_addr), (254 + k) & 255);
            chk(last_beat == 1'b0, "R7 no last", int'(last_beat), 0);
            if (k == 299) cmd_stop = 1'b1;
        end
        @(negedge clk);
        cmd_stop = 1'b0;
        chk(burst_active == 1'b0, "R7 stopped", int'(burst_active), 0);
        mode_set(11'h02F);
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_col   = 8'h05;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            chk(int'(col_addr) == 5 + k, "R7 full page linear", int'(col_addr), 5 + k);
            if (k == 3) cmd_stop = 1'b1;
        end
        @(negedge clk);
        cmd_stop = 1'b0;
        chk(burst_active == 1'b0, "R8 stop full page", int'(burst_active), 0);

        // R8 stop in a length-8 burst
        mode_set(11'h033);
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_col   = 8'h60;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            chk(int'(col_addr) == 'h60 + k, "R8 before stop", int'(col_addr), 'h60 + k);
        end
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        chk(burst_active == 1'b0, "R8 stop", int'(burst_active), 0);
        chk(last_beat == 1'b0, "R8 no last", int'(last_beat), 0);

        // R10 clock enable low freezes and ignores commands
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_col   = 8'h40;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(int'(col_addr) == 'h40, "R10 beat0", int'(col_addr), 'h40);
        @(negedge clk);
        chk(int'(col_addr) == 'h41, "R10 beat1", int'(col_addr), 'h41);
        cke        = 1'b0;
        cmd_start  = 1'b1;
        cmd_col    = 8'h99;
        mrs_valid  = 1'b1;
        mrs_opcode = 11'h022;
        cmd_stop   = 1'b1;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(int'(col_addr) == 'h41, "R10 held col", int'(col_addr), 'h41);
            chk(burst_active == 1'b1, "R10 held active", int'(burst_active), 1);
            chk(cas_latency == 2'd3, "R10 mode held", int'(cas_latency), 3);
        end
        cke       = 1'b1;
        cmd_start = 1'b0;
        mrs_valid = 1'b0;
        cmd_stop  = 1'b0;
        for (int k = 2; k < 8; k++) begin
            @(negedge clk);
            chk(int'(col_addr) == 'h40 + k, "R10 resumed", int'(col_addr), 'h40 + k);
            chk(last_beat == (k == 7), "R12 last after resume", int'(last_beat),
                int'(k == 7));
        end
        @(negedge clk);
        chk(burst_active == 1'b0, "R12 idle after resume", int'(burst_active), 0);

        // R11 restart mid-burst
        mode_set(11'h022);
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_col   = 8'h20;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(int'(col_addr) == 'h20, "R11 first", int'(col_addr), 'h20);
        @(negedge clk);
        chk(int'(col_addr) == 'h21, "R11 second", int'(col_addr), 'h21);
        cmd_start = 1'b1;
        cmd_col   = 8'h52;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            chk(int'(col_addr) == exp_col('h52, k, 4, 1'b0), "R11 restarted",
                int'(col_addr), exp_col('h52, k, 4, 1'b0));
            chk(last_beat == (k == 3), "R11 last", int'(last_beat), int'(k == 3));
        end
        @(negedge clk);
        chk(burst_active == 1'b0, "R11 idle", int'(burst_active), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule